// File: doc/BRIEF.md
# Source-Routing Frame Filter

This block makes the copy-or-discard call for a received token-ring frame that carries a routing information field. An upstream parser presents the frame one field byte at a time. Four strobes mark the byte: the access-control byte, the frame-control byte, the source-address byte that holds the routing-information indicator in bit 7, and each byte of the routing field. No serial decoding is done here. The block checks the routing control word, walks the route descriptors, and compares each adjacent pair of descriptors against seven stored ring-in/bridge/ring-out triples. It applies separate rules to specifically-routed frames, all-routes explorers and spanning-tree explorers.

The result is a one-cycle decision strobe with a copy flag. On that same strobe the block's own verdict is ORed with an external address-lookup hit, so a lookup hit always turns the result into a copy. Three error counters live inside the block and are readable at its ports: duplicate ring-out, all-routes limit exceeded and spanning-tree limit exceeded. Configuration is applied as static inputs: the triples, the longest allowed routing field, a descriptor limit for each explorer type, a frame-type select mask and an explorer-disable bit.

Top module: `route_frame_filter`

## Requirements
- R1: When `ac_stb` is high and bit 4 (the token bit) of the byte is 0, the frame is a token. It produces no decision strobe.
- R2: When bit 7 of the `sa_stb` byte (the routing-information indicator) is 0, the frame produces no decision, and the block waits for the next access-control byte.
- R3: When the indicator is 1, the frame type is taken from bits 7:6 of the frame-control byte. That type selects a 2-bit field `cfg_type_sel[2*type+1:2*type]`. A value of 00 discards at once, 01 copies at once, and 1x continues into the routing field. An immediate decision is strobed in the cycle after the source-address byte.
- R4: The first routing byte holds the routing type in bits 7:5 and the field length in bytes in bits 4:0. A length that is zero, odd, or greater than `cfg_max_len` causes a discard, strobed in the cycle after that byte. The remaining bytes of the frame are then ignored.
- R5: A routing type of 0xx is a specifically-routed frame, 10x is an all-routes explorer and 11x is a spanning-tree explorer. The number of descriptors is (length-2)/2.
- R6: Each descriptor is two bytes, high byte first, holding a 12-bit ring number above a 4-bit bridge number. A specifically-routed frame is copied when some stored triple matches an adjacent descriptor pair and that triple's ring-out number occurs exactly once among the descriptors' rings.
- R7: A specifically-routed frame is discarded if a matched triple's ring-out number occurs more than once, and `cnt_dup` then increments. It is also discarded, with no counter change, when no triple matches.
- R8: An explorer whose descriptor count is greater than or equal to its type's limit (`cfg_are_lim` or `cfg_ste_lim`) is discarded. The matching counter (`cnt_are` or `cnt_ste`) then increments.
- R9: An all-routes explorer in which a stored ring-in number occurs more than once is discarded. When `cfg_ste_off` is 1, every spanning-tree explorer is discarded and `cnt_ste` does not change. An explorer that no rule discards is copied, and this includes one with length 2.
- R10: A decision that depends on the descriptors is strobed two cycles after the last routing byte, never earlier. Among the block's own rules a discard wins over a copy. The output `dec_copy` is the block's verdict ORed with `lk_hit`, sampled in the deciding cycle.
- R11: Bit 7 of the second routing byte sets the direction. With 0, a pair matches when the earlier descriptor carries the ring-in and bridge numbers and the later descriptor carries the ring-out. With 1, the earlier descriptor carries the ring-out and bridge numbers and the later one carries the ring-in.
- R12: After reset `dec_vld` is 0 and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ac_stb | input | 1 | Byte is the access-control byte; starts a new frame |
| fc_stb | input | 1 | Byte is the frame-control byte |
| sa_stb | input | 1 | Byte carries the routing-information indicator in bit 7 |
| rif_stb | input | 1 | Byte is part of the routing field |
| fld_byte | input | 8 | Field byte qualified by the strobes |
| lk_hit | input | 1 | External address-lookup copy verdict |
| cfg_lin | input | 84 | Seven 12-bit ring-in numbers, triple j at [12j+11:12j] |
| cfg_bn | input | 28 | Seven 4-bit bridge numbers, triple j at [4j+3:4j] |
| cfg_lout | input | 84 | Seven 12-bit ring-out numbers, triple j at [12j+11:12j] |
| cfg_max_len | input | 5 | Longest routing field allowed, in bytes |
| cfg_are_lim | input | 4 | Descriptor limit for all-routes explorers |
| cfg_ste_lim | input | 4 | Descriptor limit for spanning-tree explorers |
| cfg_type_sel | input | 8 | Per-frame-type action, 2 bits per type |
| cfg_ste_off | input | 1 | Discard all spanning-tree explorers |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_copy | output | 1 | Copy (1) or discard (0), valid with dec_vld |
| cnt_dup | output | 16 | Duplicate ring-out count |
| cnt_are | output | 16 | All-routes limit-exceeded count |
| cnt_ste | output | 16 | Spanning-tree limit-exceeded count |

## Verification
Two functions can land in the same deciding cycle. One is the block's own verdict with its counter pulse. The other is the ORing in of the external lookup hit. Directed frames raise `lk_hit` on a specifically-routed frame whose route matches no triple, and the expected result is a copy even though the block itself would discard. A second pairing puts a discarding rule and a copy condition in one frame, such as a matched triple whose ring-out occurs twice. For that frame the bench expects a discard and a single counter step. The strobe timing is checked separately: a bad length must be decided one cycle after its byte, and a descriptor-driven verdict must not have appeared by the time the last byte is driven.

// File: rtl/rff_pkg.sv
// Package rff_pkg
// Shared types and helpers for the source-routing frame filter.
package rff_pkg;

    // Parser progress through one frame
    typedef enum logic [2:0] {
        ST_IDLE, ST_FC, ST_SA, ST_RCF0, ST_RCF1, ST_RD, ST_DEC
    } rff_state_e;

    // Route classes decoded from the 3-bit routing type
    typedef enum logic [1:0] {
        RC_SPEC, RC_ALL, RC_TREE
    } route_cls_e;

    // Error-counter slots
    localparam int CI_DUP = 0;
    localparam int CI_ARE = 1;
    localparam int CI_STE = 2;
    localparam int N_CNT  = 3;

    // Map a routing type onto its class: 0xx, 10x, 11x
    function automatic route_cls_e rt_class(input logic [2:0] rt);
        if (!rt[2])      return RC_SPEC;
        else if (!rt[1]) return RC_ALL;
        else             return RC_TREE;
    endfunction

endpackage

// File: rtl/rff_err_cnt.sv
// Module rff_err_cnt
// Wrapping event counter. Assumes inc is a one-cycle pulse.
module rff_err_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count one step per pulse; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rff_rd_match.sv
// Module rff_rd_match
// Compares every adjacent descriptor pair against the stored triples
// and tracks how often each stored ring-in and ring-out ring occurs.
// Assumes rd_vld pulses once per completed descriptor and clr precedes
// each frame's descriptors.
module rff_rd_match #(
    parameter int N_TRIP = 7,
    parameter int RING_W = 12,
    parameter int BRG_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     rd_vld,
    input  logic                     dir_rev,
    input  logic [RING_W-1:0]        rd_ring,
    input  logic [BRG_W-1:0]         rd_brg,
    input  logic [N_TRIP*RING_W-1:0] cfg_lin,
    input  logic [N_TRIP*BRG_W-1:0]  cfg_bn,
    input  logic [N_TRIP*RING_W-1:0] cfg_lout,
    output logic [N_TRIP-1:0]        hit,
    output logic [N_TRIP-1:0]        lout_multi,
    output logic [N_TRIP-1:0]        lin_multi
);
    logic [RING_W-1:0] prev_ring;
    logic [BRG_W-1:0]  prev_brg;
    logic              have_prev;

    // Hold the previous descriptor of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_ring <= '0;
            prev_brg  <= '0;
            have_prev <= 1'b0;
        end else if (rd_vld) begin
            prev_ring <= rd_ring;
            prev_brg  <= rd_brg;
            have_prev <= 1'b1;
        end
    end

    for (genvar j = 0; j < N_TRIP; j++) begin : g_trip
        logic [RING_W-1:0] lin_j, lout_j;
        logic [BRG_W-1:0]  bn_j;
        logic              fwd_hit, rev_hit, pair_hit;
        logic [1:0]        lout_cnt, lin_cnt;

        assign lin_j  = cfg_lin [j*RING_W +: RING_W];
        assign lout_j = cfg_lout[j*RING_W +: RING_W];
        assign bn_j   = cfg_bn  [j*BRG_W  +: BRG_W];

        // Pair test in frame order (forward) or reversed
        always_comb begin
            fwd_hit  = have_prev && prev_ring == lin_j  && prev_brg == bn_j && rd_ring == lout_j;
            rev_hit  = have_prev && prev_ring == lout_j && prev_brg == bn_j && rd_ring == lin_j;
            pair_hit = dir_rev ? rev_hit : fwd_hit;
        end

        // Sticky match flag and saturating occurrence counts
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                hit[j]   <= 1'b0;
                lout_cnt <= '0;
                lin_cnt  <= '0;
            end else if (rd_vld) begin
                if (pair_hit) hit[j] <= 1'b1;
                if (rd_ring == lout_j && lout_cnt != 2'd2) lout_cnt <= lout_cnt + 1'b1;
                if (rd_ring == lin_j  && lin_cnt  != 2'd2) lin_cnt  <= lin_cnt  + 1'b1;
            end
        end

        assign lout_multi[j] = lout_cnt[1];
        assign lin_multi[j]  = lin_cnt[1];

        // R6
        lout_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[j] |-> lout_cnt != 2'd0)
            else $error("matched triple without its ring-out seen");
    end
endmodule

// File: rtl/route_frame_filter.sv
// Module route_frame_filter
// Copy/discard decision for token-ring frames carrying a routing field.
// Assumes at most one strobe per cycle and two-byte descriptors
// (RING_W + BRG_W == 16). A new access-control strobe restarts parsing.
module route_frame_filter
    import rff_pkg::*;
#(
    parameter int N_TRIP = 7,
    parameter int RING_W = 12,
    parameter int BRG_W  = 4,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ac_stb,
    input  logic                     fc_stb,
    input  logic                     sa_stb,
    input  logic                     rif_stb,
    input  logic [7:0]               fld_byte,
    input  logic                     lk_hit,
    input  logic [N_TRIP*RING_W-1:0] cfg_lin,
    input  logic [N_TRIP*BRG_W-1:0]  cfg_bn,
    input  logic [N_TRIP*RING_W-1:0] cfg_lout,
    input  logic [LEN_W-1:0]         cfg_max_len,
    input  logic [LEN_W-2:0]         cfg_are_lim,
    input  logic [LEN_W-2:0]         cfg_ste_lim,
    input  logic [7:0]               cfg_type_sel,
    input  logic                     cfg_ste_off,
    output logic                     dec_vld,
    output logic                     dec_copy,
    output logic [CNT_W-1:0]         cnt_dup,
    output logic [CNT_W-1:0]         cnt_are,
    output logic [CNT_W-1:0]         cnt_ste
);
    localparam int RD_W  = RING_W + BRG_W;
    localparam int RDC_W = LEN_W - 1;

    rff_state_e       state_q;
    logic [1:0]       ft_q;
    logic [2:0]       rt_q;
    logic             dir_q, half_q, own_copy_q;
    logic [RDC_W-1:0] rd_total_q, rd_left_q;
    logic [7:0]       hi_q;
    logic [1:0]       sel;
    logic [LEN_W-1:0] lth;
    logic             len_bad, rd_vld, own_c, are_over, ste_over;
    logic [RD_W-1:0]  rd_word;
    logic [N_TRIP-1:0] m_hit, m_lout2, m_lin2;
    logic [N_CNT-1:0]  inc;
    logic [N_CNT*CNT_W-1:0] cnt_flat;

    // Byte-level decode of the current field byte
    always_comb begin
        sel     = cfg_type_sel[2*ft_q +: 2];
        lth     = fld_byte[LEN_W-1:0];
        len_bad = (lth == '0) || lth[0] || (lth > cfg_max_len);
        rd_vld  = (state_q == ST_RD) && rif_stb && half_q;
        rd_word = {hi_q, fld_byte};
    end

    rff_rd_match #(.N_TRIP(N_TRIP), .RING_W(RING_W), .BRG_W(BRG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .clr(ac_stb), .rd_vld(rd_vld), .dir_rev(dir_q),
        .rd_ring(rd_word[RD_W-1 -: RING_W]), .rd_brg(rd_word[BRG_W-1:0]),
        .cfg_lin(cfg_lin), .cfg_bn(cfg_bn), .cfg_lout(cfg_lout),
        .hit(m_hit), .lout_multi(m_lout2), .lin_multi(m_lin2)
    );

    // End-of-field verdict and counter pulses per route class
    always_comb begin
        own_c    = 1'b0;
        inc      = '0;
        are_over = rd_total_q >= cfg_are_lim;
        ste_over = rd_total_q >= cfg_ste_lim;
        case (rt_class(rt_q))
            RC_SPEC: begin
                inc[CI_DUP] = |(m_hit & m_lout2);
                own_c       = (|m_hit) && !inc[CI_DUP];
            end
            RC_ALL: begin
                inc[CI_ARE] = are_over;
                own_c       = !are_over && !(|m_lin2);
            end
            default: begin
                inc[CI_STE] = ste_over && !cfg_ste_off;
                own_c       = !ste_over && !cfg_ste_off;
            end
        endcase
        if (state_q != ST_DEC) inc = '0;
    end

    // Frame parser and decision register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ft_q <= '0; rt_q <= '0; dir_q <= 1'b0; half_q <= 1'b0; hi_q <= '0;
            rd_total_q <= '0; rd_left_q <= '0;
            dec_vld <= 1'b0; dec_copy <= 1'b0; own_copy_q <= 1'b0;
        end else begin
            dec_vld <= 1'b0;
            case (state_q)
                ST_FC: if (fc_stb) begin
                    ft_q    <= fld_byte[7:6];
                    state_q <= ST_SA;
                end
                ST_SA: if (sa_stb) begin
                    if (!fld_byte[7]) state_q <= ST_IDLE;
                    else if (!sel[1]) begin
                        dec_vld    <= 1'b1;
                        own_copy_q <= sel[0];
                        dec_copy   <= sel[0] | lk_hit;
                        state_q    <= ST_IDLE;
                    end else state_q <= ST_RCF0;
                end
                ST_RCF0: if (rif_stb) begin
                    rt_q <= fld_byte[7:5];
                    if (len_bad) begin
                        dec_vld    <= 1'b1;
                        own_copy_q <= 1'b0;
                        dec_copy   <= lk_hit;
                        state_q    <= ST_IDLE;
                    end else begin
                        rd_total_q <= lth[LEN_W-1:1] - 1'b1;
                        rd_left_q  <= lth[LEN_W-1:1] - 1'b1;
                        state_q    <= ST_RCF1;
                    end
                end
                ST_RCF1: if (rif_stb) begin
                    dir_q   <= fld_byte[7];
                    half_q  <= 1'b0;
                    state_q <= (rd_left_q == '0) ? ST_DEC : ST_RD;
                end
                ST_RD: if (rif_stb) begin
                    if (!half_q) begin
                        hi_q   <= fld_byte;
                        half_q <= 1'b1;
                    end else begin
                        half_q    <= 1'b0;
                        rd_left_q <= rd_left_q - 1'b1;
                        if (rd_left_q == 1) state_q <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    dec_vld    <= 1'b1;
                    own_copy_q <= own_c;
                    dec_copy   <= own_c | lk_hit;
                    state_q    <= ST_IDLE;
                end
                default: ;
            endcase
            if (ac_stb) state_q <= fld_byte[4] ? ST_FC : ST_IDLE;
        end
    end

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        rff_err_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc[k]), .cnt(cnt_flat[k*CNT_W +: CNT_W])
        );
    end
    assign cnt_dup = cnt_flat[CI_DUP*CNT_W +: CNT_W];
    assign cnt_are = cnt_flat[CI_ARE*CNT_W +: CNT_W];
    assign cnt_ste = cnt_flat[CI_STE*CNT_W +: CNT_W];

    // R1
    token_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_stb && !fld_byte[4] && !sa_stb && !rif_stb) |=> !dec_vld)
        else $error("decision after token");
    // R4
    len_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RCF0 && rif_stb && !ac_stb && (fld_byte[4:0] == '0 || fld_byte[0]))
        |=> (dec_vld && !own_copy_q))
        else $error("bad length not discarded");
    // R10
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && own_copy_q) |-> dec_copy)
        else $error("own copy lost in merge");
    // R7
    dup_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_dup) |-> (dec_vld && !own_copy_q && !rt_q[2]))
        else $error("dup counter moved without an SRF discard");
    // R8
    are_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_are) |-> (dec_vld && !own_copy_q))
        else $error("explorer counter moved without a discard");
endmodule

// File: tb/route_frame_filter_tb_top.sv
// Directed bench for route_frame_filter.
module route_frame_filter_tb_top;
    localparam int N = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ac_stb = 0, fc_stb = 0, sa_stb = 0, rif_stb = 0, lk_hit = 0;
    logic [7:0] fld_byte = '0;
    logic [N*12-1:0] cfg_lin, cfg_lout;
    logic [N*4-1:0]  cfg_bn;
    logic [4:0] cfg_max_len = 5'd18;
    logic [3:0] cfg_are_lim = 4'd4, cfg_ste_lim = 4'd3;
    logic [7:0] cfg_type_sel = 8'hA4;  // type0=00 drop, type1=01 take, type2/3=10 check
    logic cfg_ste_off = 1'b0;
    logic dec_vld, dec_copy;
    logic [15:0] cnt_dup, cnt_are, cnt_ste;

    int n_run = 0, n_fail = 0, ndec = 0, snap = 0;
    logic last_copy = 1'b0;
    logic [15:0] rd_buf [0:15];

    always #2.5 clk = ~clk;

    route_frame_filter dut_i (
        .clk(clk), .rst_n(rst_n), .ac_stb(ac_stb), .fc_stb(fc_stb), .sa_stb(sa_stb),
        .rif_stb(rif_stb), .fld_byte(fld_byte), .lk_hit(lk_hit),
        .cfg_lin(cfg_lin), .cfg_bn(cfg_bn), .cfg_lout(cfg_lout),
        .cfg_max_len(cfg_max_len), .cfg_are_lim(cfg_are_lim), .cfg_ste_lim(cfg_ste_lim),
        .cfg_type_sel(cfg_type_sel), .cfg_ste_off(cfg_ste_off),
        .dec_vld(dec_vld), .dec_copy(dec_copy),
        .cnt_dup(cnt_dup), .cnt_are(cnt_are), .cnt_ste(cnt_ste)
    );

    // Decision monitor, sampled away from the active edge
    always @(negedge clk) if (dec_vld) begin ndec++; last_copy = dec_copy; end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // kind: 0 AC, 1 FC, 2 SA, 3 RIF, other idle
    task automatic put(input int kind, input logic [7:0] b);
        @(negedge clk); #1;
        ac_stb = (kind == 0); fc_stb = (kind == 1); sa_stb = (kind == 2); rif_stb = (kind == 3);
        fld_byte = b;
    endtask

    task automatic frame(input logic [7:0] ac, input logic [7:0] fc, input logic [7:0] sa,
                         input logic [7:0] rc0, input logic [7:0] rc1, input int nrd);
        ndec = 0;
        put(0, ac); put(1, fc); put(2, sa); put(3, rc0); put(3, rc1);
        snap = ndec;
        for (int i = 0; i < nrd; i++) begin
            put(3, rd_buf[i][15:8]); put(3, rd_buf[i][7:0]);
        end
        if (nrd > 0) snap = ndec;
        repeat (4) put(4, 8'h00);
    endtask

    function automatic logic [15:0] rd(input logic [11:0] ring, input logic [3:0] br);
        return {ring, br};
    endfunction

    task automatic t_reset();
        chk("R12", "dec_vld after reset", dec_vld, 0);
        chk("R12", "counters after reset", cnt_dup + cnt_are + cnt_ste, 0);
    endtask

    task automatic t_no_decision();
        frame(8'h00, 8'h40, 8'h80, 8'h28, 8'h00, 0);
        chk("R1", "token decisions", ndec, 0);
        frame(8'h10, 8'h40, 8'h00, 8'h28, 8'h00, 0);
        chk("R2", "RII low decisions", ndec, 0);
    endtask

    task automatic t_type_sel();
        frame(8'h10, 8'h00, 8'h80, 8'h00, 8'h00, 0);
        chk("R3", "type0 drop count", ndec, 1); chk("R3", "type0 drop copy", last_copy, 0);
        frame(8'h10, 8'h40, 8'h80, 8'h00, 8'h00, 0);
        chk("R3", "type1 take count", ndec, 1); chk("R3", "type1 take copy", last_copy, 1);
    endtask

    task automatic t_bad_len();
        frame(8'h10, 8'h80, 8'h80, 8'h00, 8'h00, 0);
        chk("R4", "zero length early strobe", snap, 1); chk("R4", "zero length copy", last_copy, 0);
        frame(8'h10, 8'h80, 8'h80, 8'h05, 8'h00, 0);
        chk("R4", "odd length copy", last_copy, 0);
        frame(8'h10, 8'hC0, 8'h80, 8'h14, 8'h00, 0);
        chk("R4", "over-max length count", ndec, 1); chk("R4", "over-max copy", last_copy, 0);
    endtask

    task automatic t_srf();
        rd_buf[0] = rd(12'h010, 4'd3); rd_buf[1] = rd(12'h020, 4'd0); rd_buf[2] = rd(12'h050, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h08, 8'h00, 3);
        chk("R10", "no early strobe", snap, 0);
        chk("R6", "SRF match copy", last_copy, 1);
        frame(8'h10, 8'h80, 8'h80, 8'h68, 8'h00, 3);  // type 011 is also specific
        chk("R5", "type 011 as SRF copy", last_copy, 1);
        rd_buf[2] = rd(12'h020, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h08, 8'h00, 3);
        chk("R7", "dup ring-out discard", last_copy, 0); chk("R7", "cnt_dup", cnt_dup, 1);
        rd_buf[0] = rd(12'h060, 4'd1); rd_buf[1] = rd(12'h070, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h06, 8'h00, 2);
        chk("R7", "no match discard", last_copy, 0); chk("R7", "cnt_dup unchanged", cnt_dup, 1);
        lk_hit = 1'b1;
        frame(8'h10, 8'h80, 8'h80, 8'h06, 8'h00, 2);
        lk_hit = 1'b0;
        chk("R10", "lookup hit forces copy", last_copy, 1);
    endtask

    task automatic t_dir();
        rd_buf[0] = rd(12'h050, 4'd0); rd_buf[1] = rd(12'h020, 4'd3); rd_buf[2] = rd(12'h010, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h08, 8'h80, 3);
        chk("R11", "reverse match copy", last_copy, 1);
        frame(8'h10, 8'h80, 8'h80, 8'h08, 8'h00, 3);
        chk("R11", "same route forward discard", last_copy, 0);
    endtask

    task automatic t_are();
        rd_buf[0] = rd(12'h010, 4'd3); rd_buf[1] = rd(12'h020, 4'd0); rd_buf[2] = rd(12'h050, 4'd0);
        rd_buf[3] = rd(12'h055, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h88, 8'h00, 3);
        chk("R9", "ARE under limit copy", last_copy, 1);
        frame(8'h10, 8'h80, 8'h80, 8'hAA, 8'h00, 4);  // type 101, 4 descriptors
        chk("R8", "ARE at limit discard", last_copy, 0); chk("R8", "cnt_are", cnt_are, 1);
        rd_buf[2] = rd(12'h010, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'h88, 8'h00, 3);
        chk("R9", "ARE ring-in twice discard", last_copy, 0); chk("R9", "cnt_are unchanged", cnt_are, 1);
        frame(8'h10, 8'h80, 8'h80, 8'h82, 8'h00, 0);
        chk("R9", "ARE length 2 copy", last_copy, 1);
    endtask

    task automatic t_ste();
        rd_buf[0] = rd(12'h010, 4'd3); rd_buf[1] = rd(12'h020, 4'd0); rd_buf[2] = rd(12'h050, 4'd0);
        frame(8'h10, 8'h80, 8'h80, 8'hC6, 8'h00, 2);
        chk("R8", "STE under limit copy", last_copy, 1);
        cfg_ste_off = 1'b1;
        frame(8'h10, 8'h80, 8'h80, 8'hE8, 8'h00, 3);  // type 111, over limit
        cfg_ste_off = 1'b0;
        chk("R9", "STE disabled discard", last_copy, 0); chk("R9", "cnt_ste unchanged", cnt_ste, 0);
        frame(8'h10, 8'h80, 8'h80, 8'hC8, 8'h00, 3);
        chk("R8", "STE at limit discard", last_copy, 0); chk("R8", "cnt_ste", cnt_ste, 1);
    endtask

    initial begin
        for (int j = 0; j < N; j++) begin
            cfg_lin[j*12 +: 12]  = 12'h0A0 + 12'(j);
            cfg_lout[j*12 +: 12] = 12'h0B0 + 12'(j);
            cfg_bn[j*4 +: 4]     = 4'(j);
        end
        cfg_lin[0 +: 12] = 12'h010; cfg_bn[0 +: 4] = 4'd3; cfg_lout[0 +: 12]  = 12'h020;
        cfg_lin[12 +: 12] = 12'h010; cfg_bn[4 +: 4] = 4'd4; cfg_lout[12 +: 12] = 12'h030;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_decision();
        t_type_sel();
        t_bad_len();
        t_srf();
        t_dir();
        t_are();
        t_ste();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(5 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule